// File: doc/BRIEF.md
# Barrel Thread Switch Unit

This block is the thread-switching core of a 16-bit barrel processor. It keeps a complete, banked register context for each of NTHR hardware threads. Each context holds an accumulator, a small general register file, a program counter, a stack pointer, two flag bits and a fixed thread number. Every clock cycle it issues exactly one instruction from one thread. It presents that thread's context on its outputs and hands it to a small execute stage. At the end of the cycle it writes the updated context back into the same thread's bank. It then moves to the next enabled thread in ascending round-robin order.

Software turns threads on and off through a single-bit write port. A thread that is switched off is skipped by the rotation. When every thread is off, the unit stops issuing and raises an idle flag. The execute stage is a minimal stub that is just rich enough to exercise every context field.

Top module: `bts_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, issue_valid_o and idle_o are 0. Only thread 0 is enabled after reset. Thread t starts with PC = PC_BASE + t*PC_STRIDE and SP = SP_TOP - t*SP_STRIDE, with ACC, registers and flags at 0. The first issue is thread 0, one cycle after reset is released.
- R2: A cycle with issue_valid_o = 1 issues exactly one instruction, from thread issue_tid_o. The pc_o, sp_o, acc_o and flags_o outputs show that thread's context. When more than one thread is enabled, two consecutive issues never come from the same thread.
- R3: Threads are chosen in ascending number after the last issued thread, wrapping from NTHR-1 to 0, and disabled threads are skipped. If only one thread is enabled, it issues every cycle.
- R4: A clock edge with en_we_i = 1 sets the enable bit of thread en_tid_i to en_val_i. The scheduling decision made at that same edge already uses the new value. The instruction issuing in that cycle still completes and writes back.
- R5: When no thread is enabled at a decision, the next cycle has issue_valid_o = 0 and idle_o = 1. The op_i and imm_i inputs of that cycle change no context. The rotation resumes from the thread after the last one that issued.
- R6: Write-back goes only to the bank of the issuing thread, at the edge that ends its cycle. The context of every other thread is unchanged.
- R7: op_i is decoded with these codes, where idx = imm_i[1:0]:
  - 0 and 7: no operation.
  - 1: ACC += imm_i, with flags_o[1] = carry out and flags_o[0] = (result == 0).
  - 2: SP -= 1.
  - 3: SP += 1.
  - 4: PC = imm_i.
  - 5: R[idx] = ACC.
  - 6: ACC = R[idx].

  Every code except 4 also does PC += 1. Only code 1 changes the flags.
- R8: PC, SP and ACC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation for the thread issuing this cycle |
| imm_i | input | 16 | Immediate / register index for the operation |
| en_we_i | input | 1 | Enable-bit write strobe |
| en_tid_i | input | $clog2(NTHR) | Thread whose enable bit is written |
| en_val_i | input | 1 | New enable value |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | $clog2(NTHR) | Thread number of the issuing thread |
| pc_o | output | 16 | Program counter of the issuing thread |
| sp_o | output | 16 | Stack pointer of the issuing thread |
| acc_o | output | 16 | Accumulator of the issuing thread |
| flags_o | output | 2 | {carry, zero} of the issuing thread |
| idle_o | output | 1 | No thread was enabled at the last decision |

## Verification
The bench targets the following cases, each with the fault it would expose:
- **Skipping:** threads are disabled mid-rotation. A scheduler that does not skip would issue a disabled thread or break the ascending order.
- **Same-edge enable:** an enable write lands on the edge of the decision it should affect. A one-cycle-late path would pick the stale thread.
- **Lone thread:** a single enabled thread must reissue back to back.
- **All disabled:** the bench checks that idle is raised, that ops driven during idle alter nothing, and that issue resumes after the last thread that issued. A wrong pointer would restart at thread 0.
- **Bank isolation:** write-back to the wrong bank, carry and zero on wrap, and PC wrap past 0xFFFF would each show up as a context mismatch the next time that thread issues.

// File: rtl/bts_pkg.sv
package bts_pkg;
   localparam int FLAG_W = 2;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_ADDI = 3'd1,
      OP_PUSH = 3'd2,
      OP_POP  = 3'd3,
      OP_JMP  = 3'd4,
      OP_STR  = 3'd5,
      OP_LDR  = 3'd6,
      OP_NOP2 = 3'd7
   } op_e;
endpackage

// File: rtl/bts_en_ctl.sv
module bts_en_ctl #(
   parameter int NTHR = 4,
   localparam int TW = $clog2(NTHR)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            we,
   input  logic [TW-1:0]   tid,
   input  logic            val,
   output logic [NTHR-1:0] en_nxt
);
   logic [NTHR-1:0] en_q;

   always_comb begin
      en_nxt = en_q;
      if (we) en_nxt[tid] = val;
   end

   always_ff @(posedge clk) begin
      if (rst) en_q <= NTHR'(1);
      else     en_q <= en_nxt;
   end
endmodule

// File: rtl/bts_rr_sched.sv
module bts_rr_sched #(
   parameter int NTHR = 4,
   localparam int TW = $clog2(NTHR)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NTHR-1:0] en_vec,
   output logic            valid_q,
   output logic            idle_q,
   output logic [TW-1:0]   tid_q
);
   logic          found;
   logic [TW-1:0] pick;

   always_comb begin
      found = 1'b0;
      pick  = tid_q;
      for (int k = 1; k <= NTHR; k++) begin
         int c;
         c = (int'(tid_q) + k) % NTHR;
         if (!found && en_vec[c[TW-1:0]]) begin
            found = 1'b1;
            pick  = c[TW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         idle_q  <= 1'b0;
         tid_q   <= TW'(NTHR - 1);
      end else begin
         valid_q <= found;
         idle_q  <= !found;
         if (found) tid_q <= pick;
      end
   end
endmodule

// File: rtl/bts_ctx_bank.sv
module bts_ctx_bank #(
   parameter int NTHR      = 4,
   parameter int DW        = 16,
   parameter int NREG      = 4,
   parameter int PC_BASE   = 'h0100,
   parameter int PC_STRIDE = 'h0100,
   parameter int SP_TOP    = 'h7FF0,
   parameter int SP_STRIDE = 'h0400,
   localparam int TW = $clog2(NTHR),
   localparam int RW = $clog2(NREG),
   localparam int FW = bts_pkg::FLAG_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [TW-1:0] rd_tid,
   output logic [DW-1:0] rd_pc,
   output logic [DW-1:0] rd_sp,
   output logic [DW-1:0] rd_acc,
   output logic [FW-1:0] rd_flg,
   output logic [DW-1:0] rd_rf [NREG],
   input  logic          wr_en,
   input  logic [TW-1:0] wr_tid,
   input  logic [DW-1:0] wr_pc,
   input  logic [DW-1:0] wr_sp,
   input  logic [DW-1:0] wr_acc,
   input  logic [FW-1:0] wr_flg,
   input  logic          wr_rf_en,
   input  logic [RW-1:0] wr_rf_idx,
   input  logic [DW-1:0] wr_rf_dat
);
   logic [DW-1:0] pc_all  [NTHR];
   logic [DW-1:0] sp_all  [NTHR];
   logic [DW-1:0] acc_all [NTHR];
   logic [FW-1:0] flg_all [NTHR];
   logic [DW-1:0] rf_all  [NTHR][NREG];

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      localparam logic [DW-1:0] PC_RST = DW'(PC_BASE + t * PC_STRIDE);
      localparam logic [DW-1:0] SP_RST = DW'(SP_TOP - t * SP_STRIDE);
      logic          we_t;
      logic [DW-1:0] pc_q, sp_q, acc_q;
      logic [FW-1:0] flg_q;
      logic [DW-1:0] rf_q [NREG];

      assign we_t = wr_en && (wr_tid == TW'(t));

      always_ff @(posedge clk) begin
         if (rst) begin
            pc_q  <= PC_RST;
            sp_q  <= SP_RST;
            acc_q <= '0;
            flg_q <= '0;
            for (int r = 0; r < NREG; r++) rf_q[r] <= '0;
         end else if (we_t) begin
            pc_q  <= wr_pc;
            sp_q  <= wr_sp;
            acc_q <= wr_acc;
            flg_q <= wr_flg;
            if (wr_rf_en) rf_q[wr_rf_idx] <= wr_rf_dat;
         end
      end

      assign pc_all[t]  = pc_q;
      assign sp_all[t]  = sp_q;
      assign acc_all[t] = acc_q;
      assign flg_all[t] = flg_q;
      assign rf_all[t]  = rf_q;
   end

   assign rd_pc  = pc_all[rd_tid];
   assign rd_sp  = sp_all[rd_tid];
   assign rd_acc = acc_all[rd_tid];
   assign rd_flg = flg_all[rd_tid];
   assign rd_rf  = rf_all[rd_tid];
endmodule

// File: rtl/bts_exec_stub.sv
module bts_exec_stub #(
   parameter int DW   = 16,
   parameter int NREG = 4,
   localparam int RW = $clog2(NREG),
   localparam int FW = bts_pkg::FLAG_W
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] imm,
   input  logic [DW-1:0] pc,
   input  logic [DW-1:0] sp,
   input  logic [DW-1:0] acc,
   input  logic [FW-1:0] flg,
   input  logic [DW-1:0] rf [NREG],
   output logic [DW-1:0] pc_n,
   output logic [DW-1:0] sp_n,
   output logic [DW-1:0] acc_n,
   output logic [FW-1:0] flg_n,
   output logic          rf_we,
   output logic [RW-1:0] rf_idx,
   output logic [DW-1:0] rf_dat
);
   import bts_pkg::*;
   logic [DW:0] sum;

   assign sum    = {1'b0, acc} + {1'b0, imm};
   assign rf_idx = imm[RW-1:0];
   assign rf_dat = acc;

   always_comb begin
      pc_n  = pc + DW'(1);
      sp_n  = sp;
      acc_n = acc;
      flg_n = flg;
      rf_we = 1'b0;
      case (op_e'(op))
         OP_ADDI: begin
            acc_n = sum[DW-1:0];
            flg_n = {sum[DW], sum[DW-1:0] == '0};
         end
         OP_PUSH: sp_n  = sp - DW'(1);
         OP_POP:  sp_n  = sp + DW'(1);
         OP_JMP:  pc_n  = imm;
         OP_STR:  rf_we = 1'b1;
         OP_LDR:  acc_n = rf[rf_idx];
         default: ;
      endcase
   end
endmodule

// File: rtl/bts_top.sv
module bts_top #(
   parameter int NTHR      = 4,
   parameter int DW        = 16,
   parameter int NREG      = 4,
   parameter int PC_BASE   = 'h0100,
   parameter int PC_STRIDE = 'h0100,
   parameter int SP_TOP    = 'h7FF0,
   parameter int SP_STRIDE = 'h0400,
   localparam int TW = $clog2(NTHR),
   localparam int RW = $clog2(NREG),
   localparam int FW = bts_pkg::FLAG_W
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [2:0]    op_i,
   input  logic [DW-1:0] imm_i,
   input  logic          en_we_i,
   input  logic [TW-1:0] en_tid_i,
   input  logic          en_val_i,
   output logic          issue_valid_o,
   output logic [TW-1:0] issue_tid_o,
   output logic [DW-1:0] pc_o,
   output logic [DW-1:0] sp_o,
   output logic [DW-1:0] acc_o,
   output logic [FW-1:0] flags_o,
   output logic          idle_o
);
   if (NTHR < 2) begin : g_bad_nthr
      $error("bts_top: NTHR must be at least 2");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("bts_top: NREG must be at least 2");
   end
   if (DW < 8) begin : g_bad_dw
      $error("bts_top: DW must be at least 8");
   end

   logic [NTHR-1:0] en_nxt;
   logic [DW-1:0]   rd_rf [NREG];
   logic [DW-1:0]   pc_n, sp_n, acc_n, rf_dat;
   logic [FW-1:0]   flg_n;
   logic            rf_we;
   logic [RW-1:0]   rf_idx;

   bts_en_ctl #(.NTHR(NTHR)) u_en (
      .clk(clk), .rst(rst), .we(en_we_i), .tid(en_tid_i), .val(en_val_i),
      .en_nxt(en_nxt)
   );

   bts_rr_sched #(.NTHR(NTHR)) u_sched (
      .clk(clk), .rst(rst), .en_vec(en_nxt),
      .valid_q(issue_valid_o), .idle_q(idle_o), .tid_q(issue_tid_o)
   );

   bts_ctx_bank #(
      .NTHR(NTHR), .DW(DW), .NREG(NREG),
      .PC_BASE(PC_BASE), .PC_STRIDE(PC_STRIDE),
      .SP_TOP(SP_TOP), .SP_STRIDE(SP_STRIDE)
   ) u_bank (
      .clk(clk), .rst(rst), .rd_tid(issue_tid_o),
      .rd_pc(pc_o), .rd_sp(sp_o), .rd_acc(acc_o), .rd_flg(flags_o), .rd_rf(rd_rf),
      .wr_en(issue_valid_o), .wr_tid(issue_tid_o),
      .wr_pc(pc_n), .wr_sp(sp_n), .wr_acc(acc_n), .wr_flg(flg_n),
      .wr_rf_en(rf_we), .wr_rf_idx(rf_idx), .wr_rf_dat(rf_dat)
   );

   bts_exec_stub #(.DW(DW), .NREG(NREG)) u_exec (
      .op(op_i), .imm(imm_i), .pc(pc_o), .sp(sp_o), .acc(acc_o), .flg(flags_o),
      .rf(rd_rf), .pc_n(pc_n), .sp_n(sp_n), .acc_n(acc_n), .flg_n(flg_n),
      .rf_we(rf_we), .rf_idx(rf_idx), .rf_dat(rf_dat)
   );
endmodule

// File: rtl/bts_top_chk.sv
module bts_top_chk #(
   parameter int NTHR = 4,
   localparam int TW = $clog2(NTHR)
) (
   input logic            clk,
   input logic            rst,
   input logic            issue_valid,
   input logic [TW-1:0]   issue_tid,
   input logic            idle,
   input logic [NTHR-1:0] en_nxt
);
   logic [NTHR-1:0] en_prev;
   logic [TW-1:0]   tid_prev;
   logic            valid_prev;
   logic [TW-1:0]   tid_succ;

   always_ff @(posedge clk) begin
      en_prev    <= en_nxt;
      tid_prev   <= issue_tid;
      valid_prev <= issue_valid;
   end

   assign tid_succ = (tid_prev == TW'(NTHR - 1)) ? '0 : tid_prev + TW'(1);

   // R5: idle and issue are exclusive
   a_r5_idle_excl: assert property (@(posedge clk) disable iff (rst)
      idle |-> !issue_valid);

   // R5: idle only when the decision saw no enabled thread
   a_r5_idle_none: assert property (@(posedge clk) disable iff (rst)
      idle |-> (en_prev == '0));

   // R3 / R4: the issued thread was enabled at its decision
   a_r3_pick_enabled: assert property (@(posedge clk) disable iff (rst)
      issue_valid |-> en_prev[issue_tid]);

   // R3: with all threads enabled, strict successor order
   a_r3_rr_full: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && valid_prev && (&en_prev)) |-> (issue_tid == tid_succ));

   // R2: no back-to-back issue from one thread when others are enabled
   a_r2_switch: assert property (@(posedge clk) disable iff (rst)
      (issue_valid && valid_prev && ($countones(en_prev) > 1)) |-> (issue_tid != tid_prev));
endmodule

bind bts_top bts_top_chk #(.NTHR(NTHR)) u_chk (
   .clk(clk), .rst(rst), .issue_valid(issue_valid_o), .issue_tid(issue_tid_o),
   .idle(idle_o), .en_nxt(en_nxt)
);

// File: tb/bts_top_tb.sv
`timescale 1ns/1ps
module bts_top_tb;
   localparam int NT = 4;
   localparam logic [15:0] PCB = 16'h0100, PCS = 16'h0100, SPT = 16'h7FF0, SPS = 16'h0400;

   logic clk = 0, rst = 1;
   logic [2:0] op_i = 0;
   logic [15:0] imm_i = 0;
   logic en_we_i = 0, en_val_i = 0;
   logic [1:0] en_tid_i = 0;
   logic issue_valid_o, idle_o;
   logic [1:0] issue_tid_o, flags_o;
   logic [15:0] pc_o, sp_o, acc_o;

   int n_tests = 0, n_fail = 0;

   always #2 clk = ~clk;

   bts_top u_dut (.*);

   // reference state
   logic [15:0] m_pc [NT], m_sp [NT], m_acc [NT];
   logic [1:0]  m_flg [NT];
   logic [15:0] m_rf [NT][4];
   logic [NT-1:0] m_en;
   logic [1:0] m_ptr;
   logic m_valid;

   // {op[25:23], imm[22:7], we[6], etid[5:4], eval[3], expv[2], exptid[1:0]}
   localparam logic [25:0] VEC [13] = '{
      {3'd1, 16'h0005, 1'b1, 2'd1, 1'b1, 1'b1, 2'd1},  // t0 ADDI, enable t1 (R4)
      {3'd1, 16'h0003, 1'b1, 2'd2, 1'b1, 1'b1, 2'd2},  // t1 ADDI, enable t2
      {3'd2, 16'h0000, 1'b1, 2'd3, 1'b1, 1'b1, 2'd3},  // t2 PUSH, enable t3
      {3'd1, 16'hFFFF, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0},  // t3 ADDI, wrap to t0 (R3)
      {3'd1, 16'hFFFB, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1},  // t0 carry+zero (R8)
      {3'd5, 16'h0001, 1'b1, 2'd2, 1'b0, 1'b1, 2'd3},  // t1 STR, disable t2 -> skip
      {3'd4, 16'h0200, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0},  // t3 JMP
      {3'd6, 16'h0001, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1},  // t0 LDR own r1 = 0 (R6)
      {3'd6, 16'h0001, 1'b1, 2'd0, 1'b0, 1'b1, 2'd3},  // t1 LDR r1, disable t0
      {3'd3, 16'h0000, 1'b1, 2'd1, 1'b0, 1'b1, 2'd3},  // t3 POP, disable t1 -> lone
      {3'd0, 16'h0000, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0},  // t3 NOP, disable t3 -> idle
      {3'd1, 16'h1234, 1'b1, 2'd2, 1'b1, 1'b1, 2'd2},  // idle op ignored, enable t2
      {3'd0, 16'h0000, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0}   // t2 NOP, enable t0
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin
         m_pc[t] = PCB + 16'(t) * PCS;
         m_sp[t] = SPT - 16'(t) * SPS;
         m_acc[t] = 0; m_flg[t] = 0;
         for (int r = 0; r < 4; r++) m_rf[t][r] = 0;
      end
      m_en = 4'b0001; m_ptr = 2'd3; m_valid = 0;
   endtask

   // one cycle: called at a negedge, returns at the next negedge
   task automatic step(input logic [2:0] op, input logic [15:0] imm,
                       input logic we, input logic [1:0] et, input logic ev);
      logic [16:0] s;
      logic found;
      int t;
      op_i = op; imm_i = imm; en_we_i = we; en_tid_i = et; en_val_i = ev;
      @(posedge clk);
      if (m_valid) begin
         t = m_ptr;
         s = {1'b0, m_acc[t]} + {1'b0, imm};
         if (op != 3'd4) m_pc[t] = m_pc[t] + 16'd1;
         case (op)
            3'd1: begin m_acc[t] = s[15:0]; m_flg[t] = {s[16], s[15:0] == 16'd0}; end
            3'd2: m_sp[t] = m_sp[t] - 16'd1;
            3'd3: m_sp[t] = m_sp[t] + 16'd1;
            3'd4: m_pc[t] = imm;
            3'd5: m_rf[t][imm[1:0]] = m_acc[t];
            3'd6: m_acc[t] = m_rf[t][imm[1:0]];
            default: ;
         endcase
      end
      if (we) m_en[et] = ev;
      found = 0;
      for (int k = 1; k <= NT; k++) begin
         logic [1:0] c;
         c = m_ptr + 2'(k);
         if (!found && m_en[c]) begin found = 1; m_ptr = c; end
      end
      m_valid = found;
      @(negedge clk);
      en_we_i = 0;
   endtask

   task automatic check_ctx(input string req);
      chk(req, "issue_valid", issue_valid_o, m_valid);
      chk("R5", "idle", idle_o, !m_valid);
      if (m_valid) begin
         chk(req, "tid", issue_tid_o, m_ptr);
         chk("R6", "pc", pc_o, m_pc[m_ptr]);
         chk("R6", "sp", sp_o, m_sp[m_ptr]);
         chk("R7", "acc", acc_o, m_acc[m_ptr]);
         chk("R7", "flags", flags_o, m_flg[m_ptr]);
      end
   endtask

   initial begin
      #(4.0 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", issue_valid_o, 0);
      chk("R1", "idle in reset", idle_o, 0);
      rst = 0;
      #0;
      chk("R1", "valid after release", issue_valid_o, 0);
      step(3'd1, 16'h0777, 0, 0, 0);   // no issue yet: op ignored
      chk("R1", "first tid", issue_tid_o, 0);
      chk("R1", "pc t0", pc_o, PCB);
      chk("R1", "sp t0", sp_o, SPT);
      check_ctx("R1");

      for (int i = 0; i < 13; i++) begin
         logic [25:0] v;
         v = VEC[i];
         step(v[25:23], v[22:7], v[6], v[5:4], v[3]);
         chk("R3", $sformatf("vec %0d valid", i), issue_valid_o, v[2]);
         if (v[2]) chk("R3", $sformatf("vec %0d tid", i), issue_tid_o, v[1:0]);
         check_ctx("R2");
      end
      chk("R4", "t1 reset sp seen", m_sp[1], SPT - SPS);

      // PC wrap on thread 0 (R8)
      step(3'd4, 16'hFFFF, 0, 0, 0);  check_ctx("R3");
      step(3'd0, 16'h0000, 0, 0, 0);  check_ctx("R3");
      chk("R8", "t0 pc at FFFF", pc_o, 16'hFFFF);
      step(3'd0, 16'h0000, 0, 0, 0);  check_ctx("R3");
      step(3'd0, 16'h0000, 0, 0, 0);  check_ctx("R3");
      chk("R8", "t0 pc wrapped", pc_o, 16'h0000);

      // reset in mid-run
      rst = 1;
      @(negedge clk); @(negedge clk);
      chk("R1", "valid in 2nd reset", issue_valid_o, 0);
      rst = 0;
      model_reset();
      step(3'd0, 16'h0000, 0, 0, 0);
      chk("R1", "tid after 2nd reset", issue_tid_o, 0);
      chk("R1", "acc cleared", acc_o, 0);
      chk("R1", "pc restart", pc_o, PCB);
      step(3'd0, 16'h0000, 0, 0, 0);
      chk("R3", "lone t0 reissues", issue_tid_o, 0);
      chk("R3", "lone t0 pc", pc_o, PCB + 16'd1);
      finish_run();
   end
endmodule